// File: doc/BRIEF.md
# Memory-to-Memory Block Transfer Sequencer

This block copies a run of bytes from one memory region to another on behalf of a DMA controller. It uses two channels: channel 0 supplies the source address and channel 1 supplies the destination address and the transfer count. After a software start, the block asks for the bus with a hold request. Once the hold is acknowledged, it runs one pair of bus cycles per byte. The read cycle fetches a byte at the source address into an internal holding register. The write cycle then stores that byte at the destination address. The block keeps the bus from the first transfer to the last.

Each bus cycle lasts four clock states, S1 to S4, and its strobe is high in S3 and S4. The memory port has fixed timing and no back-pressure. The memory must present read data on `mem_rdata` by the end of S4 of a read cycle, and must accept `mem_wdata` while `mem_wr` is high. Each address either counts up or counts down after a byte is moved. The source address can also be held fixed, so that one value fills the whole destination block. The service ends in one of two ways: the destination count wraps past zero, or `eop_in` is sampled high during a bus cycle. Either way, `eop_out` pulses and the hold request is released.

Top module: `m2m_dma_seq`

## Requirements
- R1: While idle, `sw_req` high with `mode_en` high raises `hold_req` on the next cycle, and the channel inputs are captured in that same cycle. With `mode_en` low, `sw_req` is ignored and `hold_req` stays low.
- R2: No strobe and no `addr_en` are driven while waiting for `hold_ack`. The first read state S1 begins in the cycle after `hold_ack` is sampled high.
- R3: Each transfer is 8 cycles: read S1..S4, then write S1..S4. `mem_addr` carries the source address during the read cycle and the destination address during the write cycle. `mem_rd` is high only in read S3/S4, `mem_wr` is high only in write S3/S4, and the two are never high together.
- R4: The byte on `mem_rdata` at the end of read S4 is driven on `mem_wdata` throughout the following write cycle.
- R5: After each completed write, each address steps by one. A direction bit of 0 means increment and 1 means decrement. When `src_fixed` is 1, the source address does not change.
- R6: Only the destination count decrements, once per transfer. A start with count value N moves N+1 bytes and leaves all other destination bytes untouched. `eop_out` comes 8(N+1)+1 cycles after the cycle in which `hold_ack` is raised.
- R7: At the end of a service, `eop_out` is high for exactly one cycle. In that cycle `hold_req` and `addr_en` are low, and no further strobes follow.
- R8: If `eop_in` is high at a clock edge during a bus cycle, the service ends at that edge. If the edge closes write S4, that byte is complete. Otherwise, the transfer in progress is abandoned and no further write happens.
- R9: After a service ends, a new `sw_req` is ignored until `hold_ack` has been seen low.
- R10: `addr_en` is high in every read and write state and low in all other states.
- R11: After reset, `hold_req`, `addr_en`, `mem_rd`, `mem_wr` and `eop_out` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Enables memory-to-memory mode |
| sw_req | input | 1 | Software start request for the source channel |
| hold_ack | input | 1 | Bus hold acknowledge |
| eop_in | input | 1 | External end-of-process, active high |
| src_addr | input | AW | Source start address (channel 0) |
| src_dec | input | 1 | Source direction: 0 increments, 1 decrements |
| src_fixed | input | 1 | Holds the source address constant |
| dst_addr | input | AW | Destination start address (channel 1) |
| dst_dec | input | 1 | Destination direction: 0 increments, 1 decrements |
| xfer_cnt | input | CW | Destination count; N moves N+1 bytes |
| mem_rdata | input | DW | Memory read data |
| hold_req | output | 1 | Bus hold request |
| addr_en | output | 1 | Address-enable, high during bus cycles |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data from the holding register |
| eop_out | output | 1 | End-of-process pulse |

## Verification
Results have fixed delays:
- `hold_req` one cycle after the start request.
- Read S1 one cycle after `hold_ack` is sampled.
- Each strobe state a fixed offset of 0 to 7 cycles into its 8-cycle transfer.
- `eop_out` exactly 8(N+1)+1 cycles after the acknowledge.
- For an abort, `eop_out` one cycle after the edge that samples `eop_in`.

The bench drives inputs and samples outputs on the falling edge. It walks the falling edges one at a time and compares each against the state it expects at that offset. Memory contents are checked only after `eop_out` has been seen.

// File: rtl/m2m_pkg.sv
package m2m_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_RD,
    SQ_WR,
    SQ_END,
    SQ_REL
  } sq_state_t;

  localparam int unsigned PH_W    = 2;
  localparam logic [PH_W-1:0] PH_LAST = 2'd3;

  // strobe window covers the last two states of a bus cycle
  function automatic logic strobe_phase(input logic [PH_W-1:0] ph);
    return ph[PH_W-1];
  endfunction

endpackage

// File: rtl/m2m_seq_fsm.sv
module m2m_seq_fsm
  import m2m_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic sw_req,
  input  logic hold_ack,
  input  logic eop_in,
  input  logic cnt_last,
  output logic start,
  output logic hold_req,
  output logic addr_en,
  output logic rd_cyc,
  output logic wr_cyc,
  output logic rd_strobe,
  output logic wr_strobe,
  output logic latch_en,
  output logic step_en,
  output logic eop_out
);

  sq_state_t        st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             bus_cyc, at_s4, end_now;

  assign bus_cyc  = (st_q == SQ_RD) || (st_q == SQ_WR);
  assign rd_cyc   = (st_q == SQ_RD);
  assign wr_cyc   = (st_q == SQ_WR);
  assign at_s4    = (ph_q == PH_LAST);
  assign start    = (st_q == SQ_IDLE) && mode_en && sw_req;
  assign latch_en = rd_cyc && at_s4;
  assign step_en  = wr_cyc && at_s4;
  assign end_now  = bus_cyc && (eop_in || (step_en && cnt_last));

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    unique case (st_q)
      SQ_IDLE: if (start) st_d = SQ_REQ;
      SQ_REQ: begin
        if (hold_ack) begin
          st_d = SQ_RD;
          ph_d = '0;
        end
      end
      SQ_RD, SQ_WR: begin
        if (end_now) begin
          st_d = SQ_END;
          ph_d = '0;
        end else if (at_s4) begin
          st_d = (st_q == SQ_RD) ? SQ_WR : SQ_RD;
          ph_d = '0;
        end else begin
          ph_d = ph_q + 2'd1;
        end
      end
      SQ_END: st_d = SQ_REL;
      SQ_REL: if (!hold_ack) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  assign hold_req  = (st_q == SQ_REQ) || bus_cyc;
  assign addr_en   = bus_cyc;
  assign rd_strobe = rd_cyc && strobe_phase(ph_q);
  assign wr_strobe = wr_cyc && strobe_phase(ph_q);
  assign eop_out   = (st_q == SQ_END);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe)); // R3

  AST_EOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eop_out |=> !eop_out); // R7

  AST_NO_STROBE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    eop_out |=> !(rd_strobe || wr_strobe)); // R7

endmodule

// File: rtl/m2m_chan_addr.sv
module m2m_chan_addr #(
  parameter int unsigned AW        = 16,
  parameter bit          ALLOW_FIX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] init,
  input  logic          dec,
  input  logic          fix,
  input  logic          step,
  output logic [AW-1:0] cur
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] cur_q;
  logic          dec_q, fix_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      dec_q <= 1'b0;
      fix_q <= 1'b0;
    end else if (load) begin
      cur_q <= init;
      dec_q <= dec;
      fix_q <= fix && ALLOW_FIX;
    end else if (step && !fix_q) begin
      cur_q <= dec_q ? (cur_q - ONE) : (cur_q + ONE);
    end
  end

  assign cur = cur_q;

endmodule

// File: rtl/m2m_word_cnt.sv
module m2m_word_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] init,
  input  logic          step,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= init;
    else if (step)   cnt_q <= cnt_q - CW'(1);
  end

  // the step taken while zero wraps to all ones: terminal count
  assign last = (cnt_q == '0);

endmodule

// File: rtl/m2m_hold_reg.sv
module m2m_hold_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     data_q <= '0;
    else if (latch) data_q <= din;
  end

  assign dout = data_q;

endmodule

// File: rtl/m2m_dma_seq.sv
module m2m_dma_seq #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          sw_req,
  input  logic          hold_ack,
  input  logic          eop_in,
  input  logic [AW-1:0] src_addr,
  input  logic          src_dec,
  input  logic          src_fixed,
  input  logic [AW-1:0] dst_addr,
  input  logic          dst_dec,
  input  logic [CW-1:0] xfer_cnt,
  input  logic [DW-1:0] mem_rdata,
  output logic          hold_req,
  output logic          addr_en,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          eop_out
);

  localparam int unsigned NCH = 2;
  localparam int unsigned SRC = 0;
  localparam int unsigned DST = 1;

  logic start, rd_cyc, wr_cyc, latch_en, step_en, cnt_last;
  logic [AW-1:0] ch_init [NCH];
  logic [AW-1:0] ch_cur  [NCH];
  logic          ch_dec  [NCH];
  logic          ch_fix  [NCH];

  assign ch_init[SRC] = src_addr;
  assign ch_dec[SRC]  = src_dec;
  assign ch_fix[SRC]  = src_fixed;
  assign ch_init[DST] = dst_addr;
  assign ch_dec[DST]  = dst_dec;
  assign ch_fix[DST]  = 1'b0;

  m2m_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .sw_req    (sw_req),
    .hold_ack  (hold_ack),
    .eop_in    (eop_in),
    .cnt_last  (cnt_last),
    .start     (start),
    .hold_req  (hold_req),
    .addr_en   (addr_en),
    .rd_cyc    (rd_cyc),
    .wr_cyc    (wr_cyc),
    .rd_strobe (mem_rd),
    .wr_strobe (mem_wr),
    .latch_en  (latch_en),
    .step_en   (step_en),
    .eop_out   (eop_out)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    m2m_chan_addr #(
      .AW        (AW),
      .ALLOW_FIX (c == SRC)
    ) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .init  (ch_init[c]),
      .dec   (ch_dec[c]),
      .fix   (ch_fix[c]),
      .step  (step_en),
      .cur   (ch_cur[c])
    );
  end

  m2m_word_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .init  (xfer_cnt),
    .step  (step_en),
    .last  (cnt_last)
  );

  m2m_hold_reg #(.DW(DW)) u_tmp (
    .clk   (clk),
    .rst_n (rst_n),
    .latch (latch_en),
    .din   (mem_rdata),
    .dout  (mem_wdata)
  );

  always_comb begin
    if (rd_cyc)      mem_addr = ch_cur[SRC];
    else if (wr_cyc) mem_addr = ch_cur[DST];
    else             mem_addr = '0;
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> $past(mode_en && sw_req)); // R1

  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> $stable(mem_wdata)); // R4

  AST_EOP_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    eop_out |-> (!hold_req && !addr_en)); // R7

  AST_STROBE_IN_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> addr_en); // R10

endmodule

// File: tb/sim_m2m_dma_seq.sv
module sim_m2m_dma_seq;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_en = 1'b0, sw_req = 1'b0, hold_ack = 1'b0, eop_in = 1'b0;
  logic [15:0] src_addr = '0, dst_addr = '0, xfer_cnt = '0;
  logic        src_dec = 1'b0, src_fixed = 1'b0, dst_dec = 1'b0;
  logic [7:0]  mem_rdata;
  logic        hold_req, addr_en, mem_rd, mem_wr, eop_out;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  logic [7:0]  mem [0:65535];
  int unsigned n_chk = 0, n_fail = 0, wr_count = 0;
  logic        wr_prev = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  m2m_dma_seq u0 (.*);

  // memory model: commit writes and count write pulses
  always @(posedge clk) begin
    if (rst_n && mem_wr) mem[mem_addr] <= mem_wdata;
    if (rst_n && mem_wr && !wr_prev) wr_count <= wr_count + 1;
    wr_prev <= mem_wr;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(input logic [15:0] base, input int i,
                                           input bit dec, input bit fix);
    if (fix) return base;
    return dec ? base - 16'(i) : base + 16'(i);
  endfunction

  task automatic start_svc(input logic [15:0] s, input bit sd, input bit sf,
                           input logic [15:0] d, input bit dd, input logic [15:0] n);
    @(negedge clk);
    src_addr = s; src_dec = sd; src_fixed = sf;
    dst_addr = d; dst_dec = dd; xfer_cnt = n;
    mode_en = 1'b1; sw_req = 1'b1;
    wr_count = 0;
    @(negedge clk);
    sw_req = 1'b0;
    src_addr = ~s; dst_addr = ~d; xfer_cnt = '1; // captured values must be used
    chk(hold_req == 1'b1, "R1", "hold_req after start", hold_req, 1);
  endtask

  task automatic finish_svc(input int exp_cyc);
    int cyc = 0;
    while (!eop_out && !done) begin
      @(negedge clk);
      cyc++;
    end
    if (exp_cyc >= 0) chk(cyc == exp_cyc, "R6", "cycles ack to eop", cyc, exp_cyc);
    chk(!hold_req && !addr_en, "R7", "bus released at eop", {hold_req, addr_en}, 0);
    hold_ack = 1'b0;
    @(negedge clk);
    chk(!eop_out, "R7", "eop single cycle", eop_out, 0);
    @(negedge clk);
  endtask

  task automatic check_mem(input logic [15:0] s, input bit sd, input bit sf,
                           input logic [15:0] d, input bit dd, input int nbytes,
                           input logic [7:0] guard);
    for (int i = 0; i < nbytes; i++) begin
      logic [15:0] sa, da;
      sa = exp_addr(s, i, sd, sf);
      da = exp_addr(d, i, dd, 1'b0);
      chk(mem[da] == mem[sa], "R5", "dest byte", mem[da], mem[sa]);
    end
    chk(wr_count == nbytes, "R6", "write count", wr_count, nbytes);
    chk(mem[exp_addr(d, nbytes, dd, 1'b0)] == guard, "R6", "byte past block",
        mem[exp_addr(d, nbytes, dd, 1'b0)], guard);
  endtask

  task automatic random_run(input bit sd, input bit sf, input bit dd, input int n);
    logic [15:0] s, d;
    logic [7:0]  guard;
    s = 16'h1000 + 16'($urandom_range(0, 16'h0fff));
    d = 16'h8000 + 16'($urandom_range(0, 16'h0fff));
    guard = mem[exp_addr(d, n + 1, dd, 1'b0)];
    start_svc(s, sd, sf, d, dd, 16'(n));
    repeat ($urandom_range(0, 3)) @(negedge clk);
    hold_ack = 1'b1;
    finish_svc(8 * (n + 1) + 1);
    check_mem(s, sd, sf, d, dd, n + 1, guard);
  endtask

  initial begin
    for (int a = 0; a < 65536; a++) mem[a] = 8'($urandom(32'd7) + a);
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!hold_req && !addr_en && !mem_rd && !mem_wr && !eop_out, "R11", "reset outputs",
        {hold_req, addr_en, mem_rd, mem_wr, eop_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: start ignored with mode disabled
    sw_req = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!hold_req, "R1", "no hold when mode off", hold_req, 0);
    end
    sw_req = 1'b0;

    // directed timing walk: R2 R3 R4 R5 R10
    begin
      logic [15:0] s, d;
      logic [7:0]  guard;
      s = 16'h1234; d = 16'h8800;
      guard = mem[d + 16'd2];
      start_svc(s, 1'b0, 1'b0, d, 1'b0, 16'd1);
      repeat (2) begin
        @(negedge clk);
        chk(!addr_en && !mem_rd && !mem_wr, "R2", "quiet before ack",
            {addr_en, mem_rd, mem_wr}, 0);
      end
      hold_ack = 1'b1;
      for (int c = 0; c < 16; c++) begin
        int k, p;
        logic [15:0] ea;
        @(negedge clk);
        k = c / 8; p = c % 8;
        ea = (p < 4) ? s + 16'(k) : d + 16'(k);
        chk(addr_en, "R10", "addr_en in bus cycle", addr_en, 1);
        chk(mem_addr == ea, "R3", "address in state", mem_addr, ea);
        chk(mem_rd == (p == 2 || p == 3), "R3", "read strobe", mem_rd, (p == 2 || p == 3));
        chk(mem_wr == (p == 6 || p == 7), "R3", "write strobe", mem_wr, (p == 6 || p == 7));
        if (p >= 4)
          chk(mem_wdata == mem[s + 16'(k)], "R4", "write data", mem_wdata, mem[s + 16'(k)]);
      end
      finish_svc(1);
      check_mem(s, 1'b0, 1'b0, d, 1'b0, 2, guard);
    end

    // R9: no restart until acknowledge is seen low
    begin
      start_svc(16'h1500, 1'b0, 1'b0, 16'h8500, 1'b0, 16'd0);
      hold_ack = 1'b1;
      while (!eop_out) @(negedge clk);
      @(negedge clk);
      sw_req = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk(!hold_req, "R9", "restart blocked while ack high", hold_req, 0);
      end
      sw_req = 1'b0;
      hold_ack = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R6: single byte and directed direction corners
    random_run(1'b1, 1'b0, 1'b1, 0);
    random_run(1'b0, 1'b1, 1'b1, 5);

    // R8: abort during a read cycle of the third transfer
    begin
      logic [15:0] s, d;
      logic [7:0]  g2;
      s = 16'h1800; d = 16'h8a00;
      g2 = mem[d + 16'd2];
      start_svc(s, 1'b0, 1'b0, d, 1'b0, 16'd9);
      hold_ack = 1'b1;
      do @(negedge clk); while (!(wr_count == 2 && mem_rd));
      eop_in = 1'b1;
      @(negedge clk);
      eop_in = 1'b0;
      chk(eop_out, "R8", "eop after abort in read", eop_out, 1);
      hold_ack = 1'b0;
      repeat (3) @(negedge clk);
      chk(wr_count == 2, "R8", "writes after read abort", wr_count, 2);
      chk(mem[d + 16'd1] == mem[s + 16'd1], "R8", "last full byte", mem[d + 16'd1], mem[s + 16'd1]);
      chk(mem[d + 16'd2] == g2, "R8", "abandoned byte untouched", mem[d + 16'd2], g2);
    end

    // R8: abort on write S4 completes that byte
    begin
      logic [15:0] s, d;
      logic [7:0]  g1;
      s = 16'h1900; d = 16'h8b00;
      g1 = mem[d - 16'd1];
      start_svc(s, 1'b1, 1'b0, d, 1'b1, 16'd9);
      hold_ack = 1'b1;
      do @(negedge clk); while (!mem_wr);
      @(negedge clk);
      chk(mem_wr, "R3", "write S4 strobe", mem_wr, 1);
      eop_in = 1'b1;
      @(negedge clk);
      eop_in = 1'b0;
      chk(eop_out, "R8", "eop after abort in write S4", eop_out, 1);
      hold_ack = 1'b0;
      repeat (3) @(negedge clk);
      chk(wr_count == 1, "R8", "writes after S4 abort", wr_count, 1);
      chk(mem[d] == mem[s], "R8", "completed byte", mem[d], mem[s]);
      chk(mem[d - 16'd1] == g1, "R8", "next byte untouched", mem[d - 16'd1], g1);
    end

    // constrained random transfers: R5 R6 across directions and fixed source
    for (int r = 0; r < 20; r++)
      random_run(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 30)));

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule